// File: doc/BRIEF.md
# Refresh Counter with Opcode-Fetch Classifier

This block keeps the 8-bit memory refresh register of a byte-oriented CPU core. It also decides, for every instruction byte the core fetches, whether that byte is read with an opcode-fetch (M1) cycle or with a plain memory read. The core presents one strobe per fetched byte, with the byte value and a flag that marks the first byte of a new instruction. The block answers with the cycle type for the byte on the strobe, the type it expects for the next byte of the same instruction, and the register value, which also serves as the refresh address.

The low seven bits count M1 cycles only. Prefix bytes (0xDD, 0xFD, 0xED, 0xCB) are M1 fetches, so they advance the count. The displacement and final opcode of an indexed bit instruction (0xDD or 0xFD, then 0xCB, then displacement, then opcode) are plain reads. Once a byte inside an instruction has been read with a plain read, every later byte of that instruction is also a plain read. A repeating block instruction re-fetches its opcode on every pass, so the core flags each pass as a new instruction and each pass is counted again. Software may write the whole register from the accumulator.

Top module: `refresh_tracker`

## Requirements
- R1: Asynchronous reset drives `refresh_o` to 0x00 and `m1_expect_o` to 1, whatever state the sequencer was in.
- R2: Each strobed fetch with `m1_cycle_o`=1 adds one to bits 6:0 of `refresh_o` at the next clock edge. 0x7F wraps to 0x00 and bit 7 keeps its value.
- R3: A cycle with no strobe, or a strobed fetch with `m1_cycle_o`=0, leaves `refresh_o` unchanged.
- R4: A fetch with `insn_start_i`=1 is always M1. A byte that is not a prefix ends the opcode part, and the bytes of the same instruction that follow it are plain reads. An unprefixed instruction therefore adds exactly one.
- R5: After the prefix 0xCB or 0xED, and after 0xDD or 0xFD followed by a byte that is not a prefix, the next byte is an M1 fetch. A single-prefixed instruction therefore adds exactly two.
- R6: In 0xDD 0xCB d op and 0xFD 0xCB d op, the bytes d and op are plain reads. `m1_expect_o` is 0 right after the 0xCB, and the instruction adds exactly two.
- R7: When 0xDD or 0xFD is followed by 0xDD, 0xFD or 0xED, the earlier prefix counts as one M1 fetch on its own, and the later byte is again an M1 fetch handled as a fresh prefix.
- R8: Once a fetch inside an instruction is a plain read, all later fetches without `insn_start_i` stay plain reads, and `m1_expect_o` stays 0.
- R9: `load_valid_i` writes all 8 bits of `load_data_i` into `refresh_o` at the next edge. It takes priority over an M1 increment in the same cycle.
- R10: Every pass of a repeating block instruction (0xED 0xB0 re-fetched with `insn_start_i`) adds two.
- R11: Bit 7 of `refresh_o` changes only through a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | One instruction byte is fetched this cycle |
| insn_start_i | input | 1 | The strobed byte is the first byte of an instruction |
| fetch_byte_i | input | 8 | Value of the fetched byte |
| load_valid_i | input | 1 | Write the register from the accumulator |
| load_data_i | input | 8 | Accumulator value to write |
| m1_cycle_o | output | 1 | Cycle type for the byte on the strobe: 1 = M1, 0 = plain read |
| m1_expect_o | output | 1 | Cycle type expected for the next byte of the current instruction |
| refresh_o | output | 8 | Register value, also used as the refresh address |

## Verification
If the sequencer holds the wrong state, the first symptom appears on `m1_cycle_o` at the very next strobed byte that does not start an instruction. One clock later `refresh_o` differs by one from the expected count. A missed transition into read mode appears only at the displacement byte of an indexed bit instruction, so those sequences are driven both with and without a new instruction in between. A counter fault near the 7-bit boundary affects bit 7 at once, so the wrap is checked with bit 7 both clear and set.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    SEQ_OPCODE,    // expecting first opcode byte
    SEQ_IDX_PFX,   // after index prefix
    SEQ_BIT_PFX,   // after bit-op prefix
    SEQ_EXT_PFX,   // after extended prefix
    SEQ_IDX_DISP,  // indexed bit op: displacement next (read)
    SEQ_IDX_OPND,  // indexed bit op: final opcode next (read)
    SEQ_TAIL       // operand bytes until next instruction (read)
  } seq_state_e;

  localparam logic [7:0] PFX_IX  = 8'hDD;
  localparam logic [7:0] PFX_IY  = 8'hFD;
  localparam logic [7:0] PFX_BIT = 8'hCB;
  localparam logic [7:0] PFX_EXT = 8'hED;

  function automatic logic state_is_m1(seq_state_e s);
    return (s == SEQ_OPCODE) || (s == SEQ_IDX_PFX) ||
           (s == SEQ_BIT_PFX) || (s == SEQ_EXT_PFX);
  endfunction

  function automatic seq_state_e after_opcode(logic [7:0] b);
    seq_state_e n;
    case (b)
      PFX_IX, PFX_IY: n = SEQ_IDX_PFX;
      PFX_BIT:        n = SEQ_BIT_PFX;
      PFX_EXT:        n = SEQ_EXT_PFX;
      default:        n = SEQ_TAIL;
    endcase
    return n;
  endfunction

  function automatic seq_state_e seq_next(seq_state_e s, logic [7:0] b);
    seq_state_e n;
    case (s)
      SEQ_OPCODE:   n = after_opcode(b);
      SEQ_IDX_PFX: begin
        // bit-op prefix after index prefix enters read mode; other prefixes restart
        if (b == PFX_BIT) n = SEQ_IDX_DISP;
        else              n = after_opcode(b);
      end
      SEQ_BIT_PFX:  n = SEQ_TAIL;
      SEQ_EXT_PFX:  n = SEQ_TAIL;
      SEQ_IDX_DISP: n = SEQ_IDX_OPND;
      default:      n = SEQ_TAIL;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/fetch_classifier.sv
module fetch_classifier
  import rfsh_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fetch_valid_i,
  input  logic       insn_start_i,
  input  logic [7:0] fetch_byte_i,
  output logic       m1_cycle_o,
  output logic       m1_expect_o
);

  seq_state_e state_q, state_eff, state_d;

  // a new instruction always restarts the prefix walk
  assign state_eff   = insn_start_i ? SEQ_OPCODE : state_q;
  assign state_d     = seq_next(state_eff, fetch_byte_i);
  assign m1_cycle_o  = state_is_m1(state_eff);
  assign m1_expect_o = state_is_m1(state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            state_q <= SEQ_OPCODE;
    else if (fetch_valid_i) state_q <= state_d;
  end

endmodule

// File: rtl/refresh_counter.sv
module refresh_counter #(
  parameter int DATA_W  = 8,
  parameter int COUNT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] value_o
);

  localparam int HOLD_W = DATA_W - COUNT_W;

  logic [COUNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_data_i[COUNT_W-1:0];
    else if (step_i) cnt_q <= cnt_q + COUNT_W'(1);
  end

  generate
    if (HOLD_W > 0) begin : g_hold
      logic [HOLD_W-1:0] hold_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     hold_q <= '0;
        else if (load_i) hold_q <= load_data_i[DATA_W-1:COUNT_W];
      end
      assign value_o = {hold_q, cnt_q};
    end else begin : g_full
      assign value_o = cnt_q;
    end
  endgenerate

endmodule

// File: rtl/refresh_tracker.sv
module refresh_tracker #(
  parameter int DATA_W  = 8,
  parameter int COUNT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic              insn_start_i,
  input  logic [7:0]        fetch_byte_i,
  input  logic              load_valid_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              m1_cycle_o,
  output logic              m1_expect_o,
  output logic [DATA_W-1:0] refresh_o
);

  logic m1_cycle;

  fetch_classifier i_classifier (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_valid_i(fetch_valid_i),
    .insn_start_i (insn_start_i),
    .fetch_byte_i (fetch_byte_i),
    .m1_cycle_o   (m1_cycle),
    .m1_expect_o  (m1_expect_o)
  );

  refresh_counter #(
    .DATA_W (DATA_W),
    .COUNT_W(COUNT_W)
  ) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (fetch_valid_i & m1_cycle),
    .load_i     (load_valid_i),
    .load_data_i(load_data_i),
    .value_o    (refresh_o)
  );

  assign m1_cycle_o = m1_cycle;

endmodule

// File: rtl/refresh_tracker_chk.sv
module refresh_tracker_chk #(
  parameter int DATA_W  = 8,
  parameter int COUNT_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic              insn_start_i,
  input logic              load_valid_i,
  input logic [DATA_W-1:0] load_data_i,
  input logic              m1_cycle_o,
  input logic              m1_expect_o,
  input logic [DATA_W-1:0] refresh_o
);

  AST_M1_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && m1_cycle_o && !load_valid_i) |=>
      refresh_o[COUNT_W-1:0] == COUNT_W'($past(refresh_o[COUNT_W-1:0]) + COUNT_W'(1))); // R2

  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!fetch_valid_i || !m1_cycle_o) && !load_valid_i) |=> $stable(refresh_o)); // R3

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_i |=> refresh_o == $past(load_data_i)); // R9

  AST_READ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && !insn_start_i && !m1_cycle_o) |=> !m1_expect_o); // R8

  generate
    if (DATA_W > COUNT_W) begin : g_top
      AST_TOP_BIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_valid_i |=> $stable(refresh_o[DATA_W-1])); // R11
    end
  endgenerate

endmodule

bind refresh_tracker refresh_tracker_chk #(
  .DATA_W (DATA_W),
  .COUNT_W(COUNT_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_valid_i(fetch_valid_i),
  .insn_start_i (insn_start_i),
  .load_valid_i (load_valid_i),
  .load_data_i  (load_data_i),
  .m1_cycle_o   (m1_cycle_o),
  .m1_expect_o  (m1_expect_o),
  .refresh_o    (refresh_o)
);

// File: tb/test_refresh_tracker.sv
`timescale 1ns/1ps
module test_refresh_tracker;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fetch_valid = 1'b0;
  logic       insn_start = 1'b0;
  logic [7:0] fetch_byte = 8'h00;
  logic       load_valid = 1'b0;
  logic [7:0] load_data = 8'h00;
  logic       m1_cycle, m1_expect;
  logic [7:0] refresh;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  logic [7:0] exp_r = 8'h00;

  always #2.5 clk = ~clk;

  refresh_tracker i_refresh_tracker (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .fetch_valid_i(fetch_valid),
    .insn_start_i (insn_start),
    .fetch_byte_i (fetch_byte),
    .load_valid_i (load_valid),
    .load_data_i  (load_data),
    .m1_cycle_o   (m1_cycle),
    .m1_expect_o  (m1_expect),
    .refresh_o    (refresh)
  );

  // {tag[3:0], start, expected m1, byte}
  localparam int NV = 34;
  localparam logic [13:0] VEC [NV] = '{
    {4'd4, 1'b1, 1'b1, 8'h00},
    {4'd4, 1'b1, 1'b1, 8'h3E}, {4'd4, 1'b0, 1'b0, 8'h05},
    {4'd5, 1'b1, 1'b1, 8'hDD}, {4'd5, 1'b0, 1'b1, 8'h21}, {4'd5, 1'b0, 1'b0, 8'h34}, {4'd5, 1'b0, 1'b0, 8'h12},
    {4'd6, 1'b1, 1'b1, 8'hFD}, {4'd6, 1'b0, 1'b1, 8'hCB}, {4'd6, 1'b0, 1'b0, 8'h05}, {4'd6, 1'b0, 1'b0, 8'h06},
    {4'd6, 1'b1, 1'b1, 8'hDD}, {4'd6, 1'b0, 1'b1, 8'hCB}, {4'd6, 1'b0, 1'b0, 8'hFE}, {4'd6, 1'b0, 1'b0, 8'h46},
    {4'd7, 1'b1, 1'b1, 8'hDD}, {4'd7, 1'b0, 1'b1, 8'hDD}, {4'd7, 1'b0, 1'b1, 8'h7E}, {4'd7, 1'b0, 1'b0, 8'h00},
    {4'd7, 1'b1, 1'b1, 8'hFD}, {4'd7, 1'b0, 1'b1, 8'hED}, {4'd7, 1'b0, 1'b1, 8'h4B}, {4'd7, 1'b0, 1'b0, 8'h00},
    {4'd5, 1'b1, 1'b1, 8'hCB}, {4'd5, 1'b0, 1'b1, 8'h11},
    {4'd10, 1'b1, 1'b1, 8'hED}, {4'd10, 1'b0, 1'b1, 8'hB0}, {4'd10, 1'b1, 1'b1, 8'hED}, {4'd10, 1'b0, 1'b1, 8'hB0},
    {4'd7, 1'b1, 1'b1, 8'hDD}, {4'd7, 1'b0, 1'b1, 8'hFD}, {4'd6, 1'b0, 1'b1, 8'hCB},
    {4'd6, 1'b0, 1'b0, 8'h01}, {4'd6, 1'b0, 1'b0, 8'h06}
  };

  function automatic string tag_name(logic [3:0] t);
    case (t)
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd10:   return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic do_fetch(input logic st, input logic [7:0] b, input logic em1, input string req);
    @(negedge clk);
    fetch_valid = 1'b1; insn_start = st; fetch_byte = b;
    #1 check(req, "m1_cycle", {7'd0, m1_cycle}, {7'd0, em1});
    if (em1) exp_r = {exp_r[7], exp_r[6:0] + 7'd1};
    @(posedge clk); #1;
    fetch_valid = 1'b0; insn_start = 1'b0;
    check(req, "refresh", refresh, exp_r);
  endtask

  task automatic do_load(input logic [7:0] d, input logic with_fetch, input string req);
    @(negedge clk);
    load_valid = 1'b1; load_data = d;
    fetch_valid = with_fetch; insn_start = with_fetch; fetch_byte = 8'h00;
    @(posedge clk); #1;
    load_valid = 1'b0; fetch_valid = 1'b0; insn_start = 1'b0;
    exp_r = d;
    check(req, "load", refresh, exp_r);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      finish_run();
    end
  end

  initial begin
    #12;
    // R1: reset state
    check("R1", "refresh at reset", refresh, 8'h00);
    check("R1", "m1_expect at reset", {7'd0, m1_expect}, 8'h01);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      do_fetch(VEC[i][9], VEC[i][7:0], VEC[i][8], tag_name(VEC[i][13:10]));

    // R8: read mode sticks without a new instruction
    for (int i = 0; i < 3; i++) begin
      do_fetch(1'b0, 8'hDD, 1'b0, "R8");
      check("R8", "m1_expect", {7'd0, m1_expect}, 8'h00);
    end

    // R6: expectation drops right after bit-op prefix of indexed form
    do_fetch(1'b1, 8'hFD, 1'b1, "R6");
    check("R6", "m1_expect after FD", {7'd0, m1_expect}, 8'h01);
    do_fetch(1'b0, 8'hCB, 1'b1, "R6");
    check("R6", "m1_expect after CB", {7'd0, m1_expect}, 8'h00);

    // R3: idle cycles change nothing
    repeat (3) @(posedge clk);
    #1 check("R3", "idle", refresh, exp_r);

    // R9: load wins over same-cycle M1 increment
    do_load(8'h3C, 1'b0, "R9");
    do_load(8'h7F, 1'b1, "R9");
    // R2: wrap with bit 7 clear
    do_fetch(1'b1, 8'h00, 1'b1, "R2");
    check("R2", "wrap to 00", refresh, 8'h00);
    // R11: wrap with bit 7 set keeps bit 7
    do_load(8'hFF, 1'b0, "R11");
    do_fetch(1'b1, 8'h00, 1'b1, "R11");
    check("R11", "wrap keeps bit7", refresh, 8'h80);

    // R1: reset while in displacement state
    do_fetch(1'b1, 8'hDD, 1'b1, "R1");
    do_fetch(1'b0, 8'hCB, 1'b1, "R1");
    @(negedge clk); rst_n = 1'b0;
    #1 check("R1", "refresh after reset", refresh, 8'h00);
    check("R1", "m1_expect after reset", {7'd0, m1_expect}, 8'h01);
    @(negedge clk); rst_n = 1'b1;
    exp_r = 8'h00;
    do_fetch(1'b0, 8'h46, 1'b1, "R1");

    finish_run();
  end

endmodule